// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a data cache controller with two ways per set. It sits between a processor load/store port and a memory port that moves whole lines. The set is chosen by index bits taken from the virtual address. The tag that is compared is a physical tag, which a separate translation unit delivers in the same cycle. A lookup compares both stored tags at once. A hit returns the addressed 64-bit word in the cycle the request is presented, or merges a byte-enabled store into the line.

A miss holds the processor stalled and picks a victim way, preferring a way that holds no valid line. If the victim line is dirty, it is first written out to memory. The missing line is then fetched and installed. On the next cycle the request is looked up again, hits, and completes. A store that missed is merged into the newly installed line in that same step. Stores never go to memory directly. Memory only sees a line when a dirty line is evicted.

Top module: `dc2w_cache`

## Requirements
- R1: A line is 64 bytes and there are 512 sets. Memory line addresses are the 38-bit concatenation {physical tag (29 bits), set index (9 bits)}. Word w of a line (cpu_word = w) occupies bits [64w+63:64w] of mem_wline and mem_rline.
- R2: A lookup hits only when a way is valid and its stored tag equals cpu_ptag. At most one way matches. A read hit returns the word with cpu_ready=1 and cpu_stall=0 in the same cycle.
- R3: A read miss raises cpu_stall with cpu_ready low. The block issues a fill request (mem_we=0) for {cpu_ptag, cpu_index}, installs the returned line on mem_ack, and then completes the request with the fetched data.
- R4: A write hit changes only the bytes of the selected word whose cpu_be bit is 1. It issues no memory request, and it marks the line dirty.
- R5: A write miss first fetches the line, then merges the enabled bytes into it and leaves the line dirty, without any memory write at that time.
- R6: When the victim is valid and dirty, a write request (mem_we=1) carrying the victim's address and full line content is acknowledged before the fill request starts. A clean or invalid victim produces no write request.
- R7: The victim is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the less recently used way. Every hit and every fill makes the other way the less recently used one.
- R8: After reset no line is valid, and the first access to any set misses. While idle after reset, cpu_ready, cpu_stall and mem_req are 0.
- R9: Once raised, mem_req stays high with mem_addr and mem_we unchanged until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_index | input | 9 | Set index from the virtual address |
| cpu_word | input | 3 | 64-bit word within the line |
| cpu_ptag | input | 29 | Physical tag from translation |
| cpu_wdata | input | 64 | Store data |
| cpu_be | input | 8 | Store byte enables |
| cpu_rdata | output | 64 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request held, miss in progress |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = writeback, 0 = fill |
| mem_addr | output | 38 | Line address {tag, index} |
| mem_wline | output | 512 | Writeback line data |
| mem_ack | input | 1 | Transfer done, one cycle |
| mem_rline | input | 512 | Fill line data, valid with mem_ack |

## Verification
The assertions rely on three things the processor and memory must do. The processor keeps every request field stable while cpu_stall is high. Memory pulses mem_ack for a single cycle, and only while mem_req is high. The bench drives a request at a falling edge and leaves it untouched until it has sampled cpu_ready. Its memory model raises mem_ack for one cycle after a random delay and then drops it before looking at mem_req again. Random traffic is limited to a handful of sets and tags, so that evictions of dirty lines, LRU choices and hits after fills all happen often.

// File: rtl/dc2w_pkg.sv
package dc2w_pkg;
  localparam int IDX_W  = 9;
  localparam int OFF_W  = 6;
  localparam int PA_W   = 44;
  localparam int TAG_W  = PA_W - IDX_W - OFF_W;
  localparam int SETS   = 1 << IDX_W;
  localparam int WAYS   = 2;
  localparam int WORD_W = 64;
  localparam int LINE_W = (1 << OFF_W) * 8;
  localparam int WPL    = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WPL);
  localparam int BE_W   = WORD_W / 8;
  localparam int LA_W   = TAG_W + IDX_W;

  typedef enum logic [1:0] {ST_LOOKUP, ST_EVICT, ST_REFILL} dc2w_state_e;

  // invalid way first, lowest number wins; else the least recently used one
  function automatic logic pick_victim(logic vld0, logic vld1, logic lru);
    if (!vld0) return 1'b0;
    if (!vld1) return 1'b1;
    return lru;
  endfunction

  function automatic logic [LA_W-1:0] line_addr(logic [TAG_W-1:0] t, logic [IDX_W-1:0] i);
    return {t, i};
  endfunction
endpackage

// File: rtl/dc2w_tag_store.sv
module dc2w_tag_store #(
  parameter int SETS  = 512,
  parameter int IDX_W = 9,
  parameter int TAG_W = 29,
  parameter int WAYS  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            lk_idx,
  input  logic [TAG_W-1:0]            lk_tag,
  output logic [WAYS-1:0]             way_hit,
  output logic [WAYS-1:0]             way_vld,
  output logic [WAYS-1:0]             way_dty,
  output logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  output logic                        lru_bit,
  input  logic                        touch_en,
  input  logic                        touch_way,
  input  logic                        mark_dirty,
  input  logic                        fill_en,
  input  logic                        fill_way,
  input  logic [IDX_W-1:0]            fill_idx,
  input  logic [TAG_W-1:0]            fill_tag
);
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tags [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  dty_q;
    logic             fill_here;
    logic             touch_here;

    assign fill_here  = fill_en && (fill_way == w[0]);
    assign touch_here = touch_en && (touch_way == w[0]);

    always_ff @(posedge clk) begin
      if (fill_here) tags[fill_idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= '0;
        dty_q <= '0;
      end else if (fill_here) begin
        vld_q[fill_idx] <= 1'b1;
        dty_q[fill_idx] <= 1'b0;
      end else if (touch_here && mark_dirty) begin
        dty_q[lk_idx] <= 1'b1;
      end
    end

    assign way_vld[w] = vld_q[lk_idx];
    assign way_dty[w] = dty_q[lk_idx];
    assign way_tag[w] = tags[lk_idx];
    assign way_hit[w] = vld_q[lk_idx] && (tags[lk_idx] == lk_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lru_q <= '0;
    else if (fill_en) lru_q[fill_idx] <= ~fill_way;
    else if (touch_en) lru_q[lk_idx] <= ~touch_way;
  end

  assign lru_bit = lru_q[lk_idx];

  AST_WAY_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit)); // R2
endmodule

// File: rtl/dc2w_data_way.sv
module dc2w_data_way #(
  parameter int SETS   = 512,
  parameter int IDX_W  = 9,
  parameter int LINE_W = 512,
  parameter int WORD_W = 64,
  parameter int WSEL_W = 3
) (
  input  logic                clk,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [LINE_W-1:0]   rd_line,
  input  logic                fill_en,
  input  logic [IDX_W-1:0]    fill_idx,
  input  logic [LINE_W-1:0]   fill_line,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [WSEL_W-1:0]   wr_word,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [WORD_W/8-1:0] wr_be
);
  localparam int BE_W = WORD_W / 8;
  logic [LINE_W-1:0] store [SETS];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      store[fill_idx] <= fill_line;
    end else if (wr_en) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be[b]) store[wr_idx][int'(wr_word)*WORD_W + b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  assign rd_line = store[rd_idx];
endmodule

// File: rtl/dc2w_miss_ctrl.sv
module dc2w_miss_ctrl
  import dc2w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_start,
  input  logic              vic_way,
  input  logic              vic_dirty,
  input  logic [TAG_W-1:0]  vic_tag,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              mem_ack,
  output dc2w_state_e       state,
  output logic              mem_req,
  output logic              mem_we,
  output logic [LA_W-1:0]   mem_addr,
  output logic              fill_en,
  output logic              m_way,
  output logic [IDX_W-1:0]  m_idx,
  output logic [TAG_W-1:0]  m_tag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_LOOKUP;
      m_way <= 1'b0;
      m_idx <= '0;
      m_tag <= '0;
    end else begin
      unique case (state)
        ST_LOOKUP: if (miss_start) begin
          m_way <= vic_way;
          m_idx <= req_idx;
          m_tag <= req_tag;
          state <= vic_dirty ? ST_EVICT : ST_REFILL;
        end
        ST_EVICT:  if (mem_ack) state <= ST_REFILL;
        ST_REFILL: if (mem_ack) state <= ST_LOOKUP;
        default:   state <= ST_LOOKUP;
      endcase
    end
  end

  assign mem_req  = (state != ST_LOOKUP);
  assign mem_we   = (state == ST_EVICT);
  assign mem_addr = (state == ST_EVICT) ? line_addr(vic_tag, m_idx) : line_addr(m_tag, m_idx);
  assign fill_en  = (state == ST_REFILL) && mem_ack;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9
  AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we
      && (mem_addr[IDX_W-1:0] == $past(mem_addr[IDX_W-1:0]))); // R6
endmodule

// File: rtl/dc2w_cache.sv
module dc2w_cache
  import dc2w_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_valid,
  input  logic                cpu_write,
  input  logic [IDX_W-1:0]    cpu_index,
  input  logic [WSEL_W-1:0]   cpu_word,
  input  logic [TAG_W-1:0]    cpu_ptag,
  input  logic [WORD_W-1:0]   cpu_wdata,
  input  logic [BE_W-1:0]     cpu_be,
  output logic [WORD_W-1:0]   cpu_rdata,
  output logic                cpu_ready,
  output logic                cpu_stall,
  output logic                mem_req,
  output logic                mem_we,
  output logic [LA_W-1:0]     mem_addr,
  output logic [LINE_W-1:0]   mem_wline,
  input  logic                mem_ack,
  input  logic [LINE_W-1:0]   mem_rline
);
  dc2w_state_e                state;
  logic                       idle;
  logic [IDX_W-1:0]           lk_idx;
  logic [WAYS-1:0]            way_hit, way_vld, way_dty;
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic [WAYS-1:0][LINE_W-1:0] line_rd;
  logic                       lru_bit;
  logic                       hit_any, hit_ok, hit_way;
  logic                       victim, vic_dirty, miss_start;
  logic                       fill_en, m_way;
  logic [IDX_W-1:0]           m_idx;
  logic [TAG_W-1:0]           m_tag;
  logic [LINE_W-1:0]          hit_line;

  assign idle       = (state == ST_LOOKUP);
  assign lk_idx     = idle ? cpu_index : m_idx;
  assign hit_any    = |way_hit;
  assign hit_way    = way_hit[1];
  assign hit_ok     = cpu_valid && idle && hit_any;
  assign miss_start = cpu_valid && idle && !hit_any;
  assign victim     = pick_victim(way_vld[0], way_vld[1], lru_bit);
  assign vic_dirty  = way_vld[victim] && way_dty[victim];

  dc2w_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAYS(WAYS)) tags_i (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_tag(cpu_ptag),
    .way_hit(way_hit), .way_vld(way_vld), .way_dty(way_dty), .way_tag(way_tag),
    .lru_bit(lru_bit), .touch_en(hit_ok), .touch_way(hit_way), .mark_dirty(cpu_write),
    .fill_en(fill_en), .fill_way(m_way), .fill_idx(m_idx), .fill_tag(m_tag));

  for (genvar w = 0; w < WAYS; w++) begin : g_data
    dc2w_data_way #(.SETS(SETS), .IDX_W(IDX_W), .LINE_W(LINE_W), .WORD_W(WORD_W),
                    .WSEL_W(WSEL_W)) data_i (
      .clk(clk), .rd_idx(lk_idx), .rd_line(line_rd[w]),
      .fill_en(fill_en && (m_way == w[0])), .fill_idx(m_idx), .fill_line(mem_rline),
      .wr_en(hit_ok && cpu_write && (hit_way == w[0])), .wr_idx(cpu_index),
      .wr_word(cpu_word), .wr_data(cpu_wdata), .wr_be(cpu_be));
  end

  dc2w_miss_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .miss_start(miss_start), .vic_way(victim),
    .vic_dirty(vic_dirty), .vic_tag(way_tag[m_way]), .req_tag(cpu_ptag),
    .req_idx(cpu_index), .mem_ack(mem_ack), .state(state), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .fill_en(fill_en), .m_way(m_way),
    .m_idx(m_idx), .m_tag(m_tag));

  assign hit_line  = line_rd[hit_way];
  assign cpu_rdata = hit_line[int'(cpu_word)*WORD_W +: WORD_W];
  assign mem_wline = line_rd[m_way];
  assign cpu_ready = hit_ok;
  assign cpu_stall = cpu_valid && !hit_ok;

  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req); // R4
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !hit_any |-> cpu_stall && !cpu_ready); // R3
  AST_FILL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> !mem_req); // R3
endmodule

// File: tb/dc2w_cache_tb.sv
`timescale 1ns/1ps
module dc2w_cache_tb_top;
  import dc2w_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_write = 0;
  logic [IDX_W-1:0] cpu_index = '0;
  logic [WSEL_W-1:0] cpu_word = '0;
  logic [TAG_W-1:0] cpu_ptag = '0;
  logic [WORD_W-1:0] cpu_wdata = '0;
  logic [BE_W-1:0] cpu_be = '0;
  logic [WORD_W-1:0] cpu_rdata;
  logic cpu_ready, cpu_stall, mem_req, mem_we;
  logic [LA_W-1:0] mem_addr;
  logic [LINE_W-1:0] mem_wline;
  logic mem_ack = 1'b0;
  logic [LINE_W-1:0] mem_rline = '0;

  always #2 clk = ~clk;

  dc2w_cache dut_i (.*);

  int checks = 0, errors = 0;
  int wb_cnt = 0, fill_cnt = 0;
  logic [LA_W-1:0] last_wb_addr, last_fill_addr;
  logic [LINE_W-1:0] last_wb_line;

  logic [LINE_W-1:0] bmem [logic [LA_W-1:0]];
  logic [LINE_W-1:0] gold [logic [LA_W-1:0]];
  bit [TAG_W-1:0] mtag [SETS][2];
  bit mval [SETS][2];
  bit mdty [SETS][2];
  bit mlru [SETS];

  function automatic logic [LINE_W-1:0] seed_line(logic [LA_W-1:0] a);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < WPL; w++)
      l[w*WORD_W +: WORD_W] = {a[31:0] ^ 32'h5A3C_0000, 32'(w) + {a[37:32], 26'h1234}};
    return l;
  endfunction

  function automatic logic [LINE_W-1:0] gold_line(logic [LA_W-1:0] a);
    return gold.exists(a) ? gold[a] : seed_line(a);
  endfunction

  function automatic logic [WORD_W-1:0] merge_word(logic [WORD_W-1:0] old, logic [WORD_W-1:0] nw,
                                                   logic [BE_W-1:0] be);
    logic [WORD_W-1:0] r = old;
    for (int b = 0; b < BE_W; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one-cycle ack after a random delay
  initial begin
    int wait_n = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_n == 0) wait_n = 1 + int'($urandom % 3);
        else begin
          wait_n--;
          if (wait_n == 0) begin
            if (mem_we) begin
              bmem[mem_addr] = mem_wline;
              last_wb_addr = mem_addr; last_wb_line = mem_wline; wb_cnt++;
            end else begin
              mem_rline = bmem.exists(mem_addr) ? bmem[mem_addr] : seed_line(mem_addr);
              last_fill_addr = mem_addr; fill_cnt++;
            end
            mem_ack = 1'b1;
          end
        end
      end
    end
  end

  task automatic access(bit wr, int idx, int word, logic [TAG_W-1:0] tag,
                        logic [WORD_W-1:0] wd, logic [BE_W-1:0] be);
    int h = -1, v = 0, n = 0, wb0, fl0;
    bit exp_wb;
    logic [LA_W-1:0] a, va;
    logic [LINE_W-1:0] gl;
    logic [WORD_W-1:0] expw;
    a = line_addr(tag, IDX_W'(idx));
    for (int w = 0; w < 2; w++) if (mval[idx][w] && mtag[idx][w] == tag) h = w;
    if (h < 0) v = !mval[idx][0] ? 0 : (!mval[idx][1] ? 1 : int'(mlru[idx]));
    exp_wb = (h < 0) && mval[idx][v] && mdty[idx][v];
    va = line_addr(mtag[idx][v], IDX_W'(idx));
    wb0 = wb_cnt; fl0 = fill_cnt;
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_index = IDX_W'(idx); cpu_word = WSEL_W'(word);
    cpu_ptag = tag; cpu_wdata = wd; cpu_be = be;
    #1;
    if (h >= 0) chk(cpu_ready && !cpu_stall, "R2 hit same cycle", {cpu_ready, cpu_stall}, 2'b10);
    else begin
      chk(cpu_stall && !cpu_ready, "R3 miss stalls", {cpu_ready, cpu_stall}, 2'b01);
      while (!cpu_ready && n < 100) begin @(negedge clk); #1; n++; end
      chk(cpu_ready, "R3 miss completes", cpu_ready, 1);
      chk(fill_cnt == fl0 + 1 && last_fill_addr == a, "R3 R1 fill address",
          last_fill_addr, a);
      chk(wb_cnt == wb0 + (exp_wb ? 1 : 0), "R6 R7 writeback count", wb_cnt - wb0, exp_wb);
      if (exp_wb) begin
        chk(last_wb_addr == va, "R6 R7 victim address", last_wb_addr, va);
        chk(last_wb_line == gold_line(va), "R6 victim data", last_wb_line, gold_line(va));
      end
    end
    if (h >= 0) chk(wb_cnt == wb0 && fill_cnt == fl0, "R4 no memory traffic on hit",
                    wb_cnt - wb0 + fill_cnt - fl0, 0);
    gl = gold_line(a);
    if (!wr) chk(cpu_rdata == gl[word*WORD_W +: WORD_W], "R2 R1 read data", cpu_rdata,
                 gl[word*WORD_W +: WORD_W]);
    if (h < 0) begin
      h = v; mtag[idx][v] = tag; mval[idx][v] = 1; mdty[idx][v] = 0;
    end
    mlru[idx] = (h == 0);
    if (wr) begin
      mdty[idx][h] = 1;
      expw = merge_word(gl[word*WORD_W +: WORD_W], wd, be);
      gl[word*WORD_W +: WORD_W] = expw;
      gold[a] = gl;
    end
    @(negedge clk);
    cpu_valid = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (5) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!cpu_ready && !cpu_stall && !mem_req, "R8 idle after reset",
        {cpu_ready, cpu_stall, mem_req}, 0);
    // directed: cold set, two ways, LRU, dirty eviction, write miss
    access(0, 3, 0, 29'h0AAAA, 0, 0);        // R8 cold miss, way0
    access(0, 3, 5, 29'h0BBBB, 0, 0);        // R7 second invalid way
    access(0, 3, 2, 29'h0AAAA, 0, 0);        // R2 hit, way1 now LRU
    access(1, 3, 1, 29'h0AAAA, 64'h1122_3344_5566_7788, 8'h0F); // R4 partial write hit
    access(0, 3, 1, 29'h0AAAA, 0, 0);        // R4 only low bytes changed
    access(0, 3, 0, 29'h0CCCC, 0, 0);        // R7 evicts clean LRU way
    access(0, 3, 0, 29'h0DDDD, 0, 0);        // R6 dirty victim written back first
    access(1, 7, 6, 29'h1F00F, 64'hDEAD_BEEF_0BAD_F00D, 8'hFF); // R5 write miss
    access(0, 7, 6, 29'h1F00F, 0, 0);        // R5 merged value returned
    access(0, 511, 7, 29'h1FFFFFFF, 0, 0);   // R1 top index and tag
    for (int i = 0; i < 400; i++) begin
      int sel = int'($urandom % 4);
      int ix = (sel == 0) ? 0 : (sel == 1) ? 1 : (sel == 2) ? 511 : 37;
      access(bit'($urandom % 2), ix, int'($urandom % WPL), TAG_W'(29'h100 + $urandom % 5),
             {$urandom, $urandom}, BE_W'($urandom));
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule